// File: doc/BRIEF.md
# Packed Saturating Adder/Subtractor

This block adds or subtracts two 32-bit operands that each hold a packed vector. Three packings are supported. The word packing holds one signed 32-bit lane. The halfword packing holds two signed 16-bit lanes. The byte packing holds four unsigned 8-bit lanes. A carry or borrow never crosses from one lane into the next. A per-operation switch chooses between clamping a lane that goes out of range and letting it wrap modulo the lane width.

The datapath is a row of four 8-bit unit adders. A carry cut is placed at every lane boundary of the selected packing. Signed data in integer form and signed data in fractional form use the same adder, so the block has no separate fractional mode. A single range-error flag reports whether any lane left its representable range. The flag is raised whether or not clamping was requested. The result and the flag are registered, and both appear one clock after a valid input.

Top module: `simd_satadd`

## Requirements
- R1: While reset is high, and on the first clock after it, `out_valid`, `out_res` and `out_flag` are all zero.
- R2: `out_valid` equals `in_valid` of the previous cycle. `out_res` and `out_flag` change only one cycle after a valid input, and they hold their value through idle cycles.
- R3: Format code 0 treats each operand as one signed 32-bit value. With `in_sub`=0 the result is a+b, and with `in_sub`=1 it is a-b. Without saturation the result wraps modulo 2^32. An addition of two operands with opposite signs never raises the flag.
- R4: In the signed formats (codes 0 and 1), when `in_sat`=1 a lane above its range becomes the lane maximum (0x7FFFFFFF or 0x7FFF). A lane below its range becomes the lane minimum (0x80000000 or 0x8000).
- R5: Format code 1 treats bits [31:16] and bits [15:0] as two separate signed halfword lanes. No carry or borrow passes between the two lanes.
- R6: Format code 2 treats each of the four bytes as an unsigned lane. When `in_sat`=1, a lane above 255 becomes 0xFF and a lane below 0 becomes 0x00.
- R7: `out_flag` is 1 when at least one lane of the selected format leaves its range, whatever the value of `in_sat`. Otherwise it is 0.
- R8: Format code 3 is illegal. It produces a zero result and a zero flag.
- R9: In format code 2, a byte lane that wraps (for example 0xFF+0x01 or 0x00-0x01 without saturation) leaves its neighbouring bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| in_a | input | 32 | First operand (minuend for subtraction) |
| in_b | input | 32 | Second operand (subtrahend for subtraction) |
| in_fmt | input | 2 | Packing: 0 word, 1 halfword pair, 2 byte quad, 3 illegal |
| in_sub | input | 1 | 0 add, 1 subtract |
| in_sat | input | 1 | 1 clamps out-of-range lanes, 0 wraps |
| out_valid | output | 1 | Result registered from the previous cycle's valid input |
| out_res | output | 32 | Packed result |
| out_flag | output | 1 | Some lane left its range |

## Verification
The hardest case to reach from the ports is a lane that leaves its range while a neighbouring lane in the same word ends exactly at a carry-producing boundary. Examples are 0xFFFF + 0x0001 in the low halfword, or a byte that wraps to zero. If carry cutting were wrong, the neighbouring lane would silently change by one. Directed vectors pair an overflowing or wrapping lane with neighbours whose expected value would shift under a leaked carry, in each format, with and without clamping. A stream of random operands then covers every format code, including the illegal one. These vectors are sent back to back so that the one-cycle latency is also checked under continuous input.

// File: rtl/simd_satadd_pkg.sv
package simd_satadd_pkg;

    localparam int UNIT_W  = 8;
    localparam int N_UNITS = 4;
    localparam int DATA_W  = UNIT_W * N_UNITS;
    localparam int IDX_W   = $clog2(N_UNITS);

    typedef enum logic [1:0] {
        FMT_WORD = 2'd0,
        FMT_HALF = 2'd1,
        FMT_BYTE = 2'd2,
        FMT_BAD  = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [UNIT_W-1:0] sum;
        logic              cout;
        logic              a_msb;
        logic              b_msb;
    } unit_sum_t;

    // carry into this unit is cut (restarts with the op carry-in)
    function automatic logic unit_cut(fmt_e f, int idx);
        case (f)
            FMT_WORD: return (idx == 0);
            FMT_HALF: return ((idx % 2) == 0);
            default:  return 1'b1;
        endcase
    endfunction

    // this unit holds the sign/top of its lane
    function automatic logic unit_top(fmt_e f, int idx);
        case (f)
            FMT_WORD: return (idx == N_UNITS - 1);
            FMT_HALF: return ((idx % 2) == 1);
            default:  return 1'b1;
        endcase
    endfunction

    // index of the top unit of the lane that contains unit idx
    function automatic logic [IDX_W-1:0] unit_top_idx(fmt_e f, int idx);
        case (f)
            FMT_WORD: return IDX_W'(N_UNITS - 1);
            FMT_HALF: return IDX_W'(idx | 1);
            default:  return IDX_W'(idx);
        endcase
    endfunction

    function automatic logic fmt_signed(fmt_e f);
        return (f != FMT_BYTE);
    endfunction

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
    import simd_satadd_pkg::*;
(
    input  fmt_e                          fmt,
    output logic [N_UNITS-1:0]            cut,
    output logic [N_UNITS-1:0]            top,
    output logic [N_UNITS-1:0][IDX_W-1:0] top_idx
);
    for (genvar i = 0; i < N_UNITS; i++) begin : g_map
        always_comb begin
            cut[i]     = unit_cut(fmt, i);
            top[i]     = unit_top(fmt, i);
            top_idx[i] = unit_top_idx(fmt, i);
        end
    end
endmodule

// File: rtl/simd_unit_add.sv
module simd_unit_add
    import simd_satadd_pkg::*;
(
    input  logic [UNIT_W-1:0] a,
    input  logic [UNIT_W-1:0] b,
    input  logic              sub,
    input  logic              cin,
    output unit_sum_t         res
);
    logic [UNIT_W-1:0] b_eff;
    logic [UNIT_W:0]   wide;

    always_comb begin
        b_eff     = sub ? ~b : b;
        wide      = {1'b0, a} + {1'b0, b_eff} + {{UNIT_W{1'b0}}, cin};
        res.sum   = wide[UNIT_W-1:0];
        res.cout  = wide[UNIT_W];
        res.a_msb = a[UNIT_W-1];
        res.b_msb = b_eff[UNIT_W-1];
    end
endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat
    import simd_satadd_pkg::*;
(
    input  fmt_e                          fmt,
    input  logic                          sub,
    input  logic                          sat,
    input  unit_sum_t [N_UNITS-1:0]       us,
    input  logic [N_UNITS-1:0]            top,
    input  logic [N_UNITS-1:0][IDX_W-1:0] top_idx,
    output logic [DATA_W-1:0]             res,
    output logic                          flag
);
    logic                 sgn;
    logic [N_UNITS-1:0]   ovf_u;
    logic [N_UNITS-1:0]   pos_u;

    assign sgn = fmt_signed(fmt);

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        logic              lane_ovf;
        logic              lane_pos;
        logic [UNIT_W-1:0] clamp;

        // range test as if this unit were the top of a lane
        always_comb begin
            if (sgn) begin
                ovf_u[i] = (us[i].a_msb == us[i].b_msb) &&
                           (us[i].sum[UNIT_W-1] != us[i].a_msb);
                pos_u[i] = ~us[i].a_msb;
            end else begin
                ovf_u[i] = us[i].cout ^ sub;
                pos_u[i] = ~sub;
            end
        end

        always_comb begin
            lane_ovf = ovf_u[top_idx[i]];
            lane_pos = pos_u[top_idx[i]];
            clamp    = {UNIT_W{lane_pos}};
            if (sgn && top[i])
                clamp[UNIT_W-1] = ~lane_pos;
            if (fmt == FMT_BAD)
                res[i*UNIT_W +: UNIT_W] = '0;
            else if (sat && lane_ovf)
                res[i*UNIT_W +: UNIT_W] = clamp;
            else
                res[i*UNIT_W +: UNIT_W] = us[i].sum;
        end
    end

    assign flag = (fmt != FMT_BAD) && |(ovf_u & top);
endmodule

// File: rtl/simd_satadd.sv
module simd_satadd
    import simd_satadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [1:0]        in_fmt,
    input  logic              in_sub,
    input  logic              in_sat,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res,
    output logic              out_flag
);
    fmt_e                          fmt;
    logic [N_UNITS-1:0]            cut;
    logic [N_UNITS-1:0]            top;
    logic [N_UNITS-1:0][IDX_W-1:0] top_idx;
    logic [N_UNITS-1:0]            cin;
    unit_sum_t [N_UNITS-1:0]       us;
    logic [DATA_W-1:0]             res_d;
    logic                          flag_d;

    assign fmt = fmt_e'(in_fmt);

    simd_lane_map u_map (
        .fmt     (fmt),
        .cut     (cut),
        .top     (top),
        .top_idx (top_idx)
    );

    for (genvar i = 0; i < N_UNITS; i++) begin : g_add
        if (i == 0) begin : g_first
            assign cin[i] = in_sub;
        end else begin : g_rest
            assign cin[i] = cut[i] ? in_sub : us[i-1].cout;
        end

        simd_unit_add u_unit (
            .a   (in_a[i*UNIT_W +: UNIT_W]),
            .b   (in_b[i*UNIT_W +: UNIT_W]),
            .sub (in_sub),
            .cin (cin[i]),
            .res (us[i])
        );
    end

    simd_lane_sat u_sat (
        .fmt     (fmt),
        .sub     (in_sub),
        .sat     (in_sat),
        .us      (us),
        .top     (top),
        .top_idx (top_idx),
        .res     (res_d),
        .flag    (flag_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            out_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res  <= res_d;
                out_flag <= flag_d;
            end
        end
    end
endmodule

// File: rtl/simd_satadd_chk.sv
module simd_satadd_chk
    import simd_satadd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic [1:0]        in_fmt,
    input logic              in_sub,
    input logic              in_sat,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_res,
    input logic              out_flag
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_res == '0 && !out_flag));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_res) && $stable(out_flag)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd0 && !in_sub && in_a[DATA_W-1] != in_b[DATA_W-1])
        |=> !out_flag);

    assert_word_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd0 && in_sat)
        |=> (!out_flag || out_res == 32'h7FFF_FFFF || out_res == 32'h8000_0000));

    assert_byte_floor_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd2 && in_sat && in_sub && in_a == '0)
        |=> (out_res == '0));

    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd3) |=> (out_res == '0 && !out_flag));
endmodule

bind simd_satadd simd_satadd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_fmt    (in_fmt),
    .in_sub    (in_sub),
    .in_sat    (in_sat),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_flag  (out_flag)
);

// File: tb/simd_satadd_test.sv
module simd_satadd_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_a, in_b;
    logic [1:0]  in_fmt;
    logic        in_sub, in_sat;
    logic        out_valid;
    logic [31:0] out_res;
    logic        out_flag;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] res;
        logic        flag;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] last_res  = '0;
    logic        last_flag = 1'b0;

    always #4 clk = ~clk;

    simd_satadd uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_fmt(in_fmt), .in_sub(in_sub), .in_sat(in_sat),
        .out_valid(out_valid), .out_res(out_res), .out_flag(out_flag)
    );

    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] f, input logic sub,
                                          input logic sat);
        logic [31:0] r  = '0;
        logic        fl = 1'b0;
        int          n, w;
        if (f == 2'd3) return 33'd0;
        n = (f == 2'd0) ? 1 : (f == 2'd1) ? 2 : 4;
        w = 32 / n;
        for (int k = 0; k < n; k++) begin
            longint mask, half, x, y, s, lo, hi;
            mask = (longint'(1) << w) - 1;
            half = longint'(1) << (w - 1);
            x = longint'(a >> (k * w)) & mask;
            y = longint'(b >> (k * w)) & mask;
            if (f != 2'd2) begin
                if (x >= half) x = x - 2 * half;
                if (y >= half) y = y - 2 * half;
                lo = -half;
                hi = half - 1;
            end else begin
                lo = 0;
                hi = mask;
            end
            s = sub ? x - y : x + y;
            if (s > hi || s < lo) begin
                fl = 1'b1;
                if (sat) s = (s > hi) ? hi : lo;
            end
            r = r | (32'(s & mask) << (k * w));
        end
        return {fl, r};
    endfunction

    task automatic check(input string tag, input logic [31:0] got_r, input logic [31:0] exp_r,
                         input logic got_f, input logic exp_f);
        n_cmp++;
        if (got_r !== exp_r || got_f !== exp_f) begin
            n_bad++;
            $display("FAIL %s: res=%08h flag=%0b expected res=%08h flag=%0b",
                     tag, got_r, got_f, exp_r, exp_f);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        exp_t e;
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R2: unexpected out_valid res=%08h expected no output", out_res);
            end else begin
                e = sb_q.pop_front();
                check(e.tag, out_res, e.res, out_flag, e.flag);
                last_res  = e.res;
                last_flag = e.flag;
            end
        end
    end

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [1:0] f,
                        input logic sub, input logic sat, input string tag);
        exp_t        e;
        logic [32:0] m;
        @(negedge clk);
        m      = model(a, b, f, sub, sat);
        e.res  = m[31:0];
        e.flag = m[32];
        e.tag  = tag;
        sb_q.push_back(e);
        in_valid = 1'b1;
        in_a = a; in_b = b; in_fmt = f; in_sub = sub; in_sat = sat;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_a = $urandom; in_b = $urandom;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0;
        in_fmt = '0; in_sub = 1'b0; in_sat = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", out_res, 32'h0, out_flag, 1'b0);
        check("R1 reset valid", {31'd0, out_valid}, 32'h0, 1'b0, 1'b0);
        rst = 1'b0;

        // word, back to back
        send(32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 1'b0, 1'b0, "R3 word wrap");
        send(32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 1'b0, 1'b1, "R4 word sat high");
        send(32'h8000_0000, 32'h0000_0001, 2'd0, 1'b1, 1'b1, "R4 word sat low");
        send(32'h1234_5678, 32'h1111_1111, 2'd0, 1'b0, 1'b1, "R3 word add");
        send(32'h0000_0005, 32'h0000_0007, 2'd0, 1'b1, 1'b0, "R3 word sub");
        send(32'h8000_0000, 32'h7FFF_FFFF, 2'd0, 1'b0, 1'b0, "R3 mixed sign");
        idle(3);
        // R2: output held while idle
        check("R2 hold", out_res, last_res, out_flag, last_flag);
        check("R2 idle valid", {31'd0, out_valid}, 32'h0, 1'b0, 1'b0);

        // halfwords
        send(32'h7FFF_0001, 32'h0001_FFFF, 2'd1, 1'b0, 1'b1, "R5 half sat hi lane");
        send(32'h0000_FFFF, 32'h0000_0001, 2'd1, 1'b0, 1'b0, "R5 half no carry");
        send(32'h8000_0000, 32'h0001_0001, 2'd1, 1'b1, 1'b1, "R4 half sat low");
        send(32'h0001_7FFF, 32'h0001_0001, 2'd1, 1'b0, 1'b0, "R7 low lane only");

        // bytes
        send(32'hFF01_8010, 32'h01FF_8010, 2'd2, 1'b0, 1'b1, "R6 byte sat high");
        send(32'h0010_05FF, 32'h0108_0601, 2'd2, 1'b1, 1'b1, "R6 byte sat low");
        send(32'h0000_00FF, 32'h0000_0001, 2'd2, 1'b0, 1'b0, "R9 byte wrap add");
        send(32'h0000_0000, 32'h0000_0001, 2'd2, 1'b1, 1'b0, "R9 byte wrap sub");
        send(32'h1020_3040, 32'h0102_0304, 2'd2, 1'b0, 1'b0, "R7 byte no flag");

        // illegal format
        send(32'h7FFF_FFFF, 32'h0000_0001, 2'd3, 1'b0, 1'b1, "R8 illegal");
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1'b1, 1'b0, "R8 illegal sub");
        idle(2);

        // random stream
        for (int i = 0; i < 400; i++) begin
            logic [1:0] f;
            string      t;
            f = 2'($urandom_range(0, 3));
            t = (f == 2'd0) ? "R3 random word" : (f == 2'd1) ? "R5 random half" :
                (f == 2'd2) ? "R6 random byte" : "R8 random illegal";
            send($urandom, $urandom, f, 1'($urandom), 1'($urandom), t);
            if ((i % 37) == 36) idle(2);
        end
        idle(4);

        if (sb_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
        end
        summary();
        $finish;
    end
endmodule